// File: doc/BRIEF.md
# Round-Robin Link Request Distributor

This block spreads memory requests from one upstream requester over a set of downstream serial-link lanes. All lanes serve the same address space, so the block does no address decode. A blind rotating pointer picks the target lane. Each lane keeps its own busy window, which opens when the lane takes a packet or bounces one. Requests that expect an answer leave a record in a small tag table. When an answer comes back from the link side, the table looks up its tag and returns it upstream.

The pointer moves on every cycle in which a request is presented, whether or not the request is taken. A refused request therefore lands on a different lane when it is presented again. Per-lane packet and byte counters keep a running total of accepted traffic. The block also notes range notices from the lanes and passes only lane 0's notice upstream.

Top module: `rr_link_distributor`

## Requirements
- R1: After reset the pointer is 0, no lane is busy, the tag table is empty, every statistics counter reads 0 and no range notice is recorded.
- R2: A presented request that is not refused drives exactly one bit of `dn_valid`, the bit of the lane the pointer names, and copies tag, data flag and size to the downstream fields. `up_ready` is high exactly when that lane's `dn_ready` is high.
- R3: The pointer advances by one, wrapping from N-1 to 0, on every cycle with `up_valid` high. This holds whether the request is accepted, refused for a busy lane, refused by the table, or bounced downstream.
- R4: When lane L accepts a request in cycle t with the data flag set and size S bytes, it refuses requests in cycles t+1 through t+ceil(S/BEAT_BYTES). With the data flag clear it is not made busy. A refused request drives no `dn_valid` bit.
- R5: When the selected lane drives `dn_valid` but its `dn_ready` is low, `up_ready` stays low and that lane is busy for the next cycle only.
- R6: The forwarded `dn_delay` equals `up_delay` plus FRONT_CYC plus FWD_CYC, modulo 2^DLY_W.
- R7: A request is tracked when `up_needs_rsp` is 1 and `up_answered` is 0. A tracked request is refused while the table is full or already holds its tag, and is recorded when accepted. An untracked request is never refused by the table.
- R8: A response whose tag is held in the table raises `up_rsp_valid`. It frees its entry when `up_rsp_ready` is high, and `rsp_ready` follows `up_rsp_ready`. A response with an unknown tag is consumed (`rsp_ready` high) and not forwarded.
- R9: Each accepted request adds 1 to its lane's packet counter, and adds its size to the lane's byte counter when the data flag is set (0 otherwise). Counters of other lanes hold.
- R10: `rng_up` follows `rng_note[0]` in the same cycle. A notice on any lane sets that lane's bit of `rng_seen` from the next cycle on, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream request presented |
| up_ready | output | 1 | Upstream request accepted this cycle |
| up_tag | input | TAG_W | Request tag |
| up_needs_rsp | input | 1 | Request expects a response |
| up_answered | input | 1 | Response already supplied elsewhere |
| up_has_data | input | 1 | Request carries payload |
| up_size | input | SIZE_W | Payload size in bytes |
| up_delay | input | DLY_W | Accumulated header delay |
| dn_valid | output | N | One-hot request valid per lane |
| dn_ready | input | N | Per-lane downstream ready |
| dn_tag | output | TAG_W | Forwarded tag |
| dn_has_data | output | 1 | Forwarded data flag |
| dn_size | output | SIZE_W | Forwarded size |
| dn_delay | output | DLY_W | Header delay plus forwarding latency |
| rsp_valid | input | 1 | Response from link side |
| rsp_ready | output | 1 | Response consumed |
| rsp_tag | input | TAG_W | Response tag |
| up_rsp_valid | output | 1 | Response returned upstream |
| up_rsp_ready | input | 1 | Upstream takes the response |
| up_rsp_tag | output | TAG_W | Returned tag |
| rng_note | input | N | Per-lane range notice pulse |
| rng_up | output | 1 | Range notice passed upstream |
| rng_seen | output | N | Sticky per-lane notice flags |
| stat_pkts | output | N*PKT_W | Per-lane packet counters, lane 0 in the low bits |
| stat_bytes | output | N*BYTE_W | Per-lane byte counters, lane 0 in the low bits |

## Verification
A wrong pointer value shows on the very next presented request as the wrong `dn_valid` bit. After that, every later request goes to the wrong lane. A wrong busy timer shows as `up_ready` differing from the lane's `dn_ready` within the window length, at most a few cycles. A corrupted tag-table entry shows on the next response with that tag, which is either forwarded or dropped wrongly, or on the next request with a duplicate tag. Counter faults appear in the per-lane totals one cycle after the acceptance.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
  typedef enum logic [1:0] {
    GATE_OPEN   = 2'd0,
    GATE_BUSY   = 2'd1,
    GATE_TABLE  = 2'd2,
    GATE_BOUNCE = 2'd3
  } gate_e;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rrd_pointer.sv
module rrd_pointer #(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [SEL_W-1:0] sel
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N - 1);

  logic [SEL_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = adv;
    ptr_d  = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign sel = ptr_q;
endmodule

// File: rtl/rrd_lane.sv
module rrd_lane #(
  parameter int SIZE_W  = 5,
  parameter int BEAT_LG = 2,
  parameter int PKT_W   = 16,
  parameter int BYTE_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              bounce,
  input  logic              has_data,
  input  logic [SIZE_W-1:0] size,
  output logic              busy,
  output logic [PKT_W-1:0]  pkts,
  output logic [BYTE_W-1:0] bytes
);
  localparam int WIN_W = SIZE_W - BEAT_LG + 1;
  localparam logic [SIZE_W:0] ROUND = (SIZE_W+1)'((1 << BEAT_LG) - 1);

  logic [WIN_W-1:0]  win_q, win_d;
  logic [SIZE_W:0]   rounded;
  logic [WIN_W-1:0]  beats;
  logic              win_en;
  logic [PKT_W-1:0]  pkts_q, pkts_d;
  logic [BYTE_W-1:0] bytes_q, bytes_d;
  logic              stat_en;

  always_comb begin
    rounded = {1'b0, size} + ROUND;
    beats   = has_data ? rounded[SIZE_W:BEAT_LG] : '0;
    win_en  = accept | bounce | (win_q != '0);
    if (accept)      win_d = beats;
    else if (bounce) win_d = WIN_W'(1);
    else             win_d = win_q - 1'b1;
  end

  always_comb begin
    stat_en = accept;
    pkts_d  = pkts_q + 1'b1;
    bytes_d = bytes_q + (has_data ? BYTE_W'(size) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkts_q  <= '0;
      bytes_q <= '0;
    end else if (stat_en) begin
      pkts_q  <= pkts_d;
      bytes_q <= bytes_d;
    end
  end

  assign busy  = (win_q != '0);
  assign pkts  = pkts_q;
  assign bytes = bytes_q;
endmodule

// File: rtl/rrd_tag_table.sv
module rrd_tag_table #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             release_hit,
  input  logic [TAG_W-1:0] rsp_tag,
  output logic             full,
  output logic             dup,
  output logic             hit
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [DEPTH-1:0] req_match, rsp_match, free_vec, alloc_vec;
  logic             found;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      req_match[i] = vld_q[i] && (tag_q[i] == req_tag);
      rsp_match[i] = vld_q[i] && (tag_q[i] == rsp_tag);
    end
    free_vec  = ~vld_q;
    alloc_vec = '0;
    found     = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (free_vec[i] && !found) begin
        alloc_vec[i] = alloc;
        found        = 1'b1;
      end
    end
    vld_d = (vld_q & ~(rsp_match & {DEPTH{release_hit}})) | alloc_vec;
  end

  assign full = &vld_q;
  assign dup  = |req_match;
  assign hit  = |rsp_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            tag_q[g] <= '0;
      else if (alloc_vec[g]) tag_q[g] <= req_tag;
    end
  end
endmodule

// File: rtl/rr_link_distributor.sv
module rr_link_distributor #(
  parameter int N         = 4,
  parameter int TAG_W     = 3,
  parameter int SIZE_W    = 5,
  parameter int BEAT_LG   = 2,
  parameter int DEPTH     = 4,
  parameter int FRONT_CYC = 1,
  parameter int FWD_CYC   = 2,
  parameter int DLY_W     = 8,
  parameter int PKT_W     = 16,
  parameter int BYTE_W    = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_valid,
  output logic                up_ready,
  input  logic [TAG_W-1:0]    up_tag,
  input  logic                up_needs_rsp,
  input  logic                up_answered,
  input  logic                up_has_data,
  input  logic [SIZE_W-1:0]   up_size,
  input  logic [DLY_W-1:0]    up_delay,
  output logic [N-1:0]        dn_valid,
  input  logic [N-1:0]        dn_ready,
  output logic [TAG_W-1:0]    dn_tag,
  output logic                dn_has_data,
  output logic [SIZE_W-1:0]   dn_size,
  output logic [DLY_W-1:0]    dn_delay,
  input  logic                rsp_valid,
  output logic                rsp_ready,
  input  logic [TAG_W-1:0]    rsp_tag,
  output logic                up_rsp_valid,
  input  logic                up_rsp_ready,
  output logic [TAG_W-1:0]    up_rsp_tag,
  input  logic [N-1:0]        rng_note,
  output logic                rng_up,
  output logic [N-1:0]        rng_seen,
  output logic [N*PKT_W-1:0]  stat_pkts,
  output logic [N*BYTE_W-1:0] stat_bytes
);
  import rrd_pkg::*;

  localparam int SEL_W = sel_width(N);
  localparam logic [DLY_W-1:0] LAT = DLY_W'(FRONT_CYC + FWD_CYC);

  logic [SEL_W-1:0] sel;
  logic [N-1:0]     lane_busy;
  logic [N-1:0]     accept_vec, bounce_vec;
  logic             tracked, tab_full, tab_dup, tab_hit, tab_block;
  logic             issue, rsp_take;
  gate_e            gate;
  logic [N-1:0]     seen_q, seen_d;

  rrd_pointer #(.N(N), .SEL_W(SEL_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(up_valid), .sel(sel)
  );

  always_comb begin
    tracked   = up_needs_rsp & ~up_answered;
    tab_block = tracked & (tab_full | tab_dup);
    if (lane_busy[sel])     gate = GATE_BUSY;
    else if (tab_block)     gate = GATE_TABLE;
    else if (!dn_ready[sel]) gate = GATE_BOUNCE;
    else                    gate = GATE_OPEN;
    issue    = up_valid & ((gate == GATE_OPEN) | (gate == GATE_BOUNCE));
    dn_valid = '0;
    if (issue) dn_valid[sel] = 1'b1;
    accept_vec = dn_valid & dn_ready;
    bounce_vec = dn_valid & ~dn_ready;
    up_ready   = |accept_vec;
  end

  assign dn_tag      = up_tag;
  assign dn_has_data = up_has_data;
  assign dn_size     = up_size;
  assign dn_delay    = up_delay + LAT;

  for (genvar g = 0; g < N; g++) begin : g_lane
    rrd_lane #(
      .SIZE_W(SIZE_W), .BEAT_LG(BEAT_LG), .PKT_W(PKT_W), .BYTE_W(BYTE_W)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept_vec[g]),
      .bounce   (bounce_vec[g]),
      .has_data (up_has_data),
      .size     (up_size),
      .busy     (lane_busy[g]),
      .pkts     (stat_pkts[g*PKT_W +: PKT_W]),
      .bytes    (stat_bytes[g*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    up_rsp_valid = rsp_valid & tab_hit;
    rsp_ready    = ~tab_hit | up_rsp_ready;
    rsp_take     = rsp_valid & tab_hit & up_rsp_ready;
  end
  assign up_rsp_tag = rsp_tag;

  rrd_tag_table #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_tab (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc       (up_ready & tracked),
    .req_tag     (up_tag),
    .release_hit (rsp_take),
    .rsp_tag     (rsp_tag),
    .full        (tab_full),
    .dup         (tab_dup),
    .hit         (tab_hit)
  );

  always_comb seen_d = seen_q | rng_note;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end

  assign rng_up   = rng_note[0];
  assign rng_seen = seen_q;
endmodule

// File: rtl/rrd_checker.sv
module rrd_checker #(
  parameter int N     = 4,
  parameter int SEL_W = 2,
  parameter int PKT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_valid,
  input logic             up_ready,
  input logic [N-1:0]     dn_valid,
  input logic [N-1:0]     dn_ready,
  input logic [SEL_W-1:0] sel,
  input logic [N-1:0]     lane_busy,
  input logic             tracked,
  input logic             tab_full,
  input logic             rsp_valid,
  input logic             up_rsp_valid,
  input logic [PKT_W-1:0] pkts0
);
  logic [SEL_W-1:0] sel_next;
  assign sel_next = (sel == SEL_W'(N - 1)) ? '0 : sel + 1'b1;

  p_onehot_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_valid));

  p_dn_on_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid != '0) |-> dn_valid[sel]);

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (sel == $past(sel_next)));

  p_busy_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && lane_busy[sel]) |-> (!up_ready && dn_valid == '0));

  p_bounce_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dn_valid & ~dn_ready) != '0) |=> lane_busy[$past(sel)]);

  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && tracked && tab_full) |-> !up_ready);

  p_rsp_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |-> rsp_valid);

  p_lane0_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_ready && sel == '0) |=> $stable(pkts0));
endmodule

bind rr_link_distributor rrd_checker #(
  .N(N), .SEL_W(SEL_W), .PKT_W(PKT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .up_valid     (up_valid),
  .up_ready     (up_ready),
  .dn_valid     (dn_valid),
  .dn_ready     (dn_ready),
  .sel          (sel),
  .lane_busy    (lane_busy),
  .tracked      (tracked),
  .tab_full     (tab_full),
  .rsp_valid    (rsp_valid),
  .up_rsp_valid (up_rsp_valid),
  .pkts0        (stat_pkts[PKT_W-1:0])
);

// File: tb/rr_link_distributor_test.sv
module rr_link_distributor_test;
  localparam int N = 4, TAG_W = 3, SIZE_W = 5, DLY_W = 8, PKT_W = 16, BYTE_W = 20;
  localparam int LAT = 3, BEAT = 4, DEPTH = 4, CYCLES = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic up_valid, up_ready, up_needs_rsp, up_answered, up_has_data;
  logic [TAG_W-1:0] up_tag, dn_tag, rsp_tag, up_rsp_tag;
  logic [SIZE_W-1:0] up_size, dn_size;
  logic [DLY_W-1:0] up_delay, dn_delay;
  logic [N-1:0] dn_valid, dn_ready, rng_note, rng_seen;
  logic dn_has_data, rsp_valid, rsp_ready, up_rsp_valid, up_rsp_ready, rng_up;
  logic [N*PKT_W-1:0] stat_pkts;
  logic [N*BYTE_W-1:0] stat_bytes;

  rr_link_distributor uut (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  bit [31:0] rs = 32'h1234_5679;
  function automatic bit [31:0] rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  int mptr;
  int mbusy[N];
  bit mbnc[N];
  bit tv[DEPTH];
  int tt[DEPTH];
  longint mpk[N], mby[N];

  task automatic check_stats(input string req);
    for (int i = 0; i < N; i++) begin
      chk(stat_pkts[i*PKT_W +: PKT_W] == PKT_W'(mpk[i]), req, "pkts",
          stat_pkts[i*PKT_W +: PKT_W], mpk[i]);
      chk(stat_bytes[i*BYTE_W +: BYTE_W] == BYTE_W'(mby[i]), req, "bytes",
          stat_bytes[i*BYTE_W +: BYTE_W], mby[i]);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    up_valid = 0; up_tag = 0; up_needs_rsp = 0; up_answered = 0; up_has_data = 0;
    up_size = 0; up_delay = 0; dn_ready = '1; rsp_valid = 0; rsp_tag = 0;
    up_rsp_ready = 0; rng_note = '0;
    mptr = 0;
    for (int i = 0; i < N; i++) begin mbusy[i] = 0; mbnc[i] = 0; mpk[i] = 0; mby[i] = 0; end
    for (int i = 0; i < DEPTH; i++) begin tv[i] = 0; tt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(rng_seen == '0, "R1", "rng_seen", rng_seen, 0);
    check_stats("R1");
    up_valid = 1; #1;
    chk(dn_valid == 4'b0001, "R1", "first lane", dn_valid, 1);
    up_valid = 0; #1;

    // R10: range notices
    rng_note = 4'b0100; #1;
    chk(rng_up == 1'b0, "R10", "rng_up other lane", rng_up, 0);
    @(negedge clk);
    chk(rng_seen == 4'b0100, "R10", "seen lane2", rng_seen, 4);
    rng_note = 4'b0001; #1;
    chk(rng_up == 1'b1, "R10", "rng_up lane0", rng_up, 1);
    @(negedge clk);
    rng_note = '0;
    @(negedge clk);
    chk(rng_seen == 4'b0101, "R10", "seen sticky", rng_seen, 5);

    // sweep with bench model
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      bit [31:0] a, b;
      int sel, beats, hitn, fulln, dupn;
      bit trk, blk, busy, iss, acc;
      string why;
      a = rnd(); b = rnd();
      up_valid     = (a[1:0] != 2'b00);
      dn_ready     = {a[4:2] != 3'b000, a[7:5] != 3'b000, a[10:8] != 3'b000, a[13:11] != 3'b000};
      up_tag       = a[16:14];
      up_needs_rsp = a[17];
      up_answered  = (a[20:18] == 3'b000);
      up_has_data  = a[21];
      up_size      = (cyc < 1500) ? SIZE_W'(a[24:22] * 2) : a[26:22];
      up_delay     = DLY_W'(b[7:0]);
      rsp_valid    = b[8];
      rsp_tag      = b[11:9];
      up_rsp_ready = (b[13:12] != 2'b00);
      #1;
      sel = mptr;
      trk = up_needs_rsp && !up_answered;
      fulln = 0; dupn = 0; hitn = 0;
      for (int i = 0; i < DEPTH; i++) begin
        fulln += tv[i];
        if (tv[i] && tt[i] == int'(up_tag)) dupn++;
        if (tv[i] && tt[i] == int'(rsp_tag)) hitn++;
      end
      blk  = trk && (fulln == DEPTH || dupn > 0);
      busy = mbusy[sel] > 0;
      iss  = up_valid && !busy && !blk;
      acc  = iss && dn_ready[sel];
      why  = busy ? (mbnc[sel] ? "R5" : "R4") : (blk ? "R7" : (iss && !dn_ready[sel] ? "R5" : "R2"));
      chk(dn_valid == (iss ? N'(1 << sel) : N'(0)), "R3", "dn_valid lane",
          dn_valid, iss ? (1 << sel) : 0);
      chk(up_ready == acc, why, "up_ready", up_ready, acc);
      if (iss) begin
        chk(dn_delay == DLY_W'(up_delay + LAT), "R6", "dn_delay", dn_delay, DLY_W'(up_delay + LAT));
        chk(dn_tag == up_tag && dn_size == up_size && dn_has_data == up_has_data,
            "R2", "fields", dn_tag, up_tag);
      end
      chk(up_rsp_valid == (rsp_valid && hitn > 0), "R8", "up_rsp_valid",
          up_rsp_valid, rsp_valid && hitn > 0);
      chk(rsp_ready == (hitn == 0 || up_rsp_ready), "R8", "rsp_ready",
          rsp_ready, hitn == 0 || up_rsp_ready);
      if (up_valid && !trk && !busy && dn_ready[sel])
        chk(up_ready, "R7", "untracked not blocked", up_ready, 1);
      @(posedge clk);
      for (int i = 0; i < N; i++) if (mbusy[i] > 0) mbusy[i]--;
      beats = up_has_data ? (int'(up_size) + BEAT - 1) / BEAT : 0;
      if (acc) begin
        mbusy[sel] = beats; mbnc[sel] = 0;
        mpk[sel]++;
        if (up_has_data) mby[sel] += up_size;
      end else if (iss) begin
        mbusy[sel] = 1; mbnc[sel] = 1;
      end
      if (rsp_valid && hitn > 0 && up_rsp_ready)
        for (int i = 0; i < DEPTH; i++) if (tv[i] && tt[i] == int'(rsp_tag)) tv[i] = 0;
      if (acc && trk)
        for (int i = 0; i < DEPTH; i++)
          if (!tv[i] && !(tt[i] == int'(rsp_tag) && rsp_valid && hitn > 0 && up_rsp_ready && 0)) begin
            tv[i] = 1; tt[i] = int'(up_tag); break;
          end
      if (up_valid) mptr = (mptr + 1) % N;
      @(negedge clk);
      check_stats("R9");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule